// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked user port and an asynchronous static RAM with a 17-bit address and an 8-bit data bus. Each accepted request becomes one complete single-byte SRAM cycle. The cycle uses active-low chip select, output enable and write strobe, plus a split data bus: a driven value, an input value and a driver enable. Parameters set the read and write cycle lengths in clock cycles, so the block can meet the memory's access, pulse-width and setup windows at the clock rate in use. With a 100 MHz clock, the defaults of two cycles per read and two per write cover a 12 ns memory grade.

The user raises `req` for one clock with `req_we`, the address and the write data. `busy` reports when the controller is occupied, and any request it sees while occupied is dropped. A read returns its byte on `rd_data` with a single-cycle `rd_valid` pulse.

Between accesses all strobes are high and the controller's bus driver is off. When the transfer direction changes, the controller adds one idle cycle so that the memory's output and its own driver are never on together.

Top module: `sram_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, `sram_ce_n`, `sram_oe_n` and `sram_we_n` are 1, and `sram_dq_oe`, `busy` and `rd_valid` are 0.
- R2: A request is accepted when `req` is 1 at a rising clock edge while `busy` is 0. `busy` is 1 from the next cycle until the last SRAM access cycle of that request, inclusive.
- R3: A request made while `busy` is 1 is ignored: it starts no SRAM cycle and changes no memory content.
- R4: A read (`req_we`=0) drives `sram_ce_n`=0, `sram_oe_n`=0 and `sram_we_n`=1 for exactly RD_CYCLES cycles. The address is presented in the first of these cycles and holds throughout them.
- R5: A read captures `sram_dq_in` at the clock edge that ends its last access cycle. In the next cycle `rd_valid` is 1 for one clock with the captured byte on `rd_data`, and `busy` is 0.
- R6: A write (`req_we`=1) drives `sram_ce_n`=0, `sram_we_n`=0 and `sram_oe_n`=1 for exactly WR_CYCLES consecutive cycles, with the address and `sram_dq_out` held at the request's values.
- R7: `sram_dq_oe` is 1 only in cycles where `sram_we_n` is 0. It is never 1 while `sram_oe_n` is 0.
- R8: If the new request's direction differs from the previous accepted request's, one turnaround cycle is inserted before the access. In that cycle `busy` is 1, all strobes are 1 and `sram_dq_oe` is 0. The first request after reset and same-direction requests get no turnaround cycle.
- R9: In every cycle where `busy` is 0, all three strobes are 1 and `sram_dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Request address |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | Controller occupied |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 8 | Captured read byte |
| sram_addr | output | 17 | SRAM address |
| sram_dq_out | output | 8 | Byte driven to SRAM data bus |
| sram_dq_in | input | 8 | Byte read from SRAM data bus |
| sram_dq_oe | output | 1 | Data bus driver enable |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |

## Verification
Several properties are checked by assertions on every cycle:
- the strobe combinations of reads and writes;
- address stability while the chip is selected;
- the exact write-strobe width;
- the driver never being on against an enabled memory output;
- the turnaround after each direction;
- the idle bus state;
- a valid strobe only after a read.

Other behaviour can only be shown by the bench's scenarios against its cycle model and behavioural memory. That covers which requests get dropped while busy, where exactly a turnaround cycle is or is not inserted, and whether the byte returned matches what was written at that address, including the extreme address and data values.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_TURN   = 2'd1,
        PH_ACCESS = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   is_write;
    } ctl_t;

    // A bus turnaround is owed when a previous access exists and its
    // direction differs from the one now being accepted.
    function automatic logic turn_needed(input logic had_op,
                                         input logic prev_write,
                                         input logic next_write);
        return had_op && (prev_write != next_write);
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 17,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned RD_CYCLES = 2,
    parameter int unsigned WR_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output ctl_t              ctl,
    output logic              last_beat,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_wdata
);

    localparam int unsigned MAX_CYC = max_u(RD_CYCLES, WR_CYCLES);
    localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYCLES - 1);
    localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_CYCLES - 1);

    logic [CNT_W-1:0] beat;
    logic             had_op;
    logic [CNT_W-1:0] beat_limit;

    assign beat_limit = ctl.is_write ? WR_LAST : RD_LAST;
    assign last_beat  = (ctl.phase == PH_ACCESS) && (beat == beat_limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl.phase    <= PH_IDLE;
            ctl.is_write <= 1'b0;
            beat         <= '0;
            had_op       <= 1'b0;
            op_addr      <= '0;
            op_wdata     <= '0;
        end else begin
            unique case (ctl.phase)
                PH_IDLE: begin
                    if (req) begin
                        op_addr      <= req_addr;
                        op_wdata     <= req_wdata;
                        ctl.is_write <= req_we;
                        had_op       <= 1'b1;
                        beat         <= '0;
                        ctl.phase    <= turn_needed(had_op, ctl.is_write, req_we)
                                        ? PH_TURN : PH_ACCESS;
                    end
                end
                PH_TURN: begin
                    ctl.phase <= PH_ACCESS;
                end
                PH_ACCESS: begin
                    if (last_beat) begin
                        ctl.phase <= PH_IDLE;
                    end else begin
                        beat <= beat + 1'b1;
                    end
                end
                default: begin
                    ctl.phase <= PH_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic              last_beat,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_wdata,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    logic in_access;
    logic rd_take;

    assign in_access   = (ctl.phase == PH_ACCESS);
    assign sram_addr   = op_addr;
    assign sram_dq_out = op_wdata;
    assign sram_ce_n   = !in_access;
    assign sram_oe_n   = !(in_access && !ctl.is_write);
    assign sram_we_n   = !(in_access && ctl.is_write);
    assign sram_dq_oe  = in_access && ctl.is_write;
    assign rd_take     = last_beat && !ctl.is_write;

    // Sample on the edge closing the final read beat; the memory's output
    // hold time covers the strobes and address moving on that same edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_take;
            if (rd_take) begin
                rd_data <= sram_dq_in;
            end
        end
    end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 17,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned RD_CYCLES = 2,
    parameter int unsigned WR_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic              sram_dq_oe,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n
);

    ctl_t              ctl;
    logic              last_beat;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_wdata;

    assign busy = (ctl.phase != PH_IDLE);

    sram_ctrl_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .RD_CYCLES(RD_CYCLES), .WR_CYCLES(WR_CYCLES)
    ) u_seq (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .ctl(ctl), .last_beat(last_beat),
        .op_addr(op_addr), .op_wdata(op_wdata)
    );

    sram_ctrl_pins #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_pins (
        .clk(clk), .rst(rst), .ctl(ctl), .last_beat(last_beat),
        .op_addr(op_addr), .op_wdata(op_wdata), .sram_dq_in(sram_dq_in),
        .sram_addr(sram_addr), .sram_dq_out(sram_dq_out),
        .sram_dq_oe(sram_dq_oe), .sram_ce_n(sram_ce_n),
        .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
    parameter int unsigned ADDR_W    = 17,
    parameter int unsigned WR_CYCLES = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              busy,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_dq_oe,
    input logic              sram_ce_n,
    input logic              sram_oe_n,
    input logic              sram_we_n
);

    logic [15:0] we_low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_low_cnt <= '0;
        end else if (!sram_we_n) begin
            we_low_cnt <= we_low_cnt + 16'd1;
        end else begin
            we_low_cnt <= '0;
        end
    end

    assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req));

    assert_rd_strobes_R4: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> (!sram_ce_n && sram_we_n));

    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

    assert_rd_valid_R5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (!busy && $past(!sram_oe_n)));

    assert_wr_strobes_R6: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> (!sram_ce_n && sram_oe_n));

    assert_we_width_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> (we_low_cnt == 16'(WR_CYCLES)));

    assert_drv_we_R7: assert property (@(posedge clk) disable iff (rst)
        sram_dq_oe |-> (!sram_we_n && sram_oe_n));

    assert_turn_wr_rd_R8: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |=> sram_oe_n);

    assert_turn_rd_wr_R8: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |=> !sram_dq_oe);

    assert_idle_bus_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe));

endmodule

bind sram_ctrl sram_ctrl_chk #(
    .ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)
) u_chk (
    .clk(clk), .rst(rst), .req(req), .busy(busy), .rd_valid(rd_valid),
    .sram_addr(sram_addr), .sram_dq_oe(sram_dq_oe), .sram_ce_n(sram_ce_n),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n)
);

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;

    localparam int AW = 17;
    localparam int DW = 8;
    localparam int RDC = 2;
    localparam int WRC = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          busy, rd_valid;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] sram_addr;
    logic [DW-1:0] sram_dq_out, sram_dq_in;
    logic          sram_dq_oe, sram_ce_n, sram_oe_n, sram_we_n;

    int checks = 0;
    int errors = 0;
    bit started = 1'b0;

    always #2.5 clk = ~clk;

    sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RD_CYCLES(RDC), .WR_CYCLES(WRC)) u_dut (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in),
        .sram_dq_oe(sram_dq_oe), .sram_ce_n(sram_ce_n),
        .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n)
    );

    // Behavioural asynchronous memory
    logic [DW-1:0] sram_mem [int];

    function automatic logic [DW-1:0] mem_get(input int a);
        return sram_mem.exists(a) ? sram_mem[a] : 8'h00;
    endfunction

    assign sram_dq_in = (!sram_ce_n && !sram_oe_n && sram_we_n)
                        ? mem_get(int'(sram_addr)) : 8'h00;

    always @(posedge clk) begin
        if (!sram_ce_n && !sram_we_n && sram_dq_oe) sram_mem[int'(sram_addr)] = sram_dq_out;
    end

    // Cycle reference model
    logic [DW-1:0] ref_mem [int];
    int            m_turn = 0;
    int            m_acc = 0;
    bit            m_we = 1'b0;
    bit            m_had = 1'b0;
    int            m_addr = 0;
    logic [DW-1:0] m_wdata = '0;
    bit            m_valid = 1'b0;
    logic [DW-1:0] m_rdata = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_turn = 0; m_acc = 0; m_had = 1'b0; m_valid = 1'b0; m_we = 1'b0;
        end else begin
            m_valid = 1'b0;
            if (m_turn > 0) begin
                m_turn = m_turn - 1;
            end else if (m_acc > 0) begin
                m_acc = m_acc - 1;
                if (m_acc == 0 && !m_we) begin
                    m_valid = 1'b1;
                    m_rdata = ref_mem.exists(m_addr) ? ref_mem[m_addr] : 8'h00;
                end
            end else if (req) begin
                m_turn  = (m_had && (m_we != req_we)) ? 1 : 0;
                m_we    = req_we;
                m_had   = 1'b1;
                m_addr  = int'(req_addr);
                m_wdata = req_wdata;
                m_acc   = req_we ? WRC : RDC;
                if (req_we) ref_mem[m_addr] = req_wdata;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !rst) begin
            chk("R2 busy", int'(busy), (m_turn > 0 || m_acc > 0) ? 1 : 0);
            if (m_turn == 0 && m_acc > 0 && !m_we) begin
                chk("R4 read ce_n", int'(sram_ce_n), 0);
                chk("R4 read oe_n", int'(sram_oe_n), 0);
                chk("R4 read we_n", int'(sram_we_n), 1);
                chk("R4 read addr", int'(sram_addr), m_addr);
                chk("R7 no drive on read", int'(sram_dq_oe), 0);
            end else if (m_turn == 0 && m_acc > 0) begin
                chk("R6 write ce_n", int'(sram_ce_n), 0);
                chk("R6 write oe_n", int'(sram_oe_n), 1);
                chk("R6 write we_n", int'(sram_we_n), 0);
                chk("R6 write addr", int'(sram_addr), m_addr);
                chk("R6 write data", int'(sram_dq_out), int'(m_wdata));
                chk("R7 drive on write", int'(sram_dq_oe), 1);
            end else if (m_turn > 0) begin
                chk("R8 turn strobes", int'({sram_ce_n, sram_oe_n, sram_we_n}), 7);
                chk("R8 turn driver", int'(sram_dq_oe), 0);
            end else begin
                chk("R9 idle strobes", int'({sram_ce_n, sram_oe_n, sram_we_n}), 7);
                chk("R9 idle driver", int'(sram_dq_oe), 0);
            end
            chk("R5 rd_valid", int'(rd_valid), int'(m_valid));
            if (m_valid) chk("R5 rd_data", int'(rd_data), int'(m_rdata));
        end
    end

    task automatic issue(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 50 && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic read_get(input logic [AW-1:0] a, output logic [DW-1:0] d);
        issue(1'b0, a, 8'h00);
        d = 'x;
        for (int i = 0; i < 20; i++) begin
            if (rd_valid) begin
                d = rd_data;
                break;
            end
            @(negedge clk);
        end
        wait_idle();
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [DW-1:0] got;
        int gap;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 during reset
        chk("R1 strobes in reset", int'({sram_ce_n, sram_oe_n, sram_we_n}), 7);
        chk("R1 driver in reset", int'(sram_dq_oe), 0);
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 rd_valid in reset", int'(rd_valid), 0);
        rst = 1'b0;
        started = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", int'(busy), 0);

        // R8: first op after reset is a write with no turnaround
        issue(1'b1, 17'h00010, 8'h5A);
        chk("R8 first op busy without turn", int'(busy), 1);
        chk("R8 first op in access", int'(sram_we_n), 0);
        wait_idle();
        issue(1'b1, 17'h1FFFF, 8'hFF);
        wait_idle();
        issue(1'b1, 17'h00000, 8'h00);
        wait_idle();

        // Write followed by read: turnaround cycle (R8)
        issue(1'b0, 17'h00010, 8'h00);
        chk("R8 turn cycle strobes", int'({sram_ce_n, sram_oe_n, sram_we_n}), 7);
        wait_idle();
        read_get(17'h1FFFF, got);
        chk("R5 max address readback", int'(got), 8'hFF);
        read_get(17'h00000, got);
        chk("R5 zero byte readback", int'(got), 8'h00);

        // R3: write, then a second write attempted while busy
        issue(1'b1, 17'h0ABCD, 8'h3C);
        issue(1'b1, 17'h0ABCD, 8'hC3);
        wait_idle();
        issue(1'b1, 17'h01234, 8'h77);
        wait_idle();
        read_get(17'h0ABCD, got);
        chk("R3 ignored write left data", int'(got), 8'h3C);

        // R2: request held high; consecutive reads accepted one idle cycle apart
        @(negedge clk);
        req = 1'b1; req_we = 1'b0; req_addr = 17'h01234;
        gap = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (rd_valid) gap++;
        end
        req = 1'b0;
        wait_idle();
        chk("R2 held request read count", gap, 4);

        // Read followed by write: turnaround cycle (R8)
        issue(1'b1, 17'h00055, 8'hA5);
        chk("R8 rd-to-wr turn driver off", int'(sram_dq_oe), 0);
        wait_idle();
        read_get(17'h00055, got);
        chk("R6 written byte readback", int'(got), 8'hA5);

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule